// File: doc/BRIEF.md
# Successive-Approximation Converter Control Core

This block is the digital half of a 16-bit successive-approximation converter. It watches an active-low chip select and a read/convert line, both sampled on the system clock. When both have been low for a qualifying number of clocks, it takes BUSY low. It then runs one bit trial per bit position against a single comparator input, most significant bit first. At completion it loads the result into an output register and releases BUSY. The analog side (capacitor array, hold switch, reference) sits outside. It sees only the trial code this block presents and answers on the comparator line.

The result is read on two 8-bit lanes. Each lane carries an enable flag that stands in for a tri-state pad. A byte-select input swaps which half of the word appears on which lane. The previous result stays readable while a new conversion runs. A second qualified low pulse on the read/convert line during a conversion aborts it and leaves the register untouched. A start that comes too soon after the previous conversion ended, before the input could be acquired again, marks its result as untrustworthy.

The controller has five states. S_IDLE waits, with BUSY high. S_QUAL counts the clocks for which both control lines are low. S_CONV runs the bit trials. S_LATCH loads the output register. S_ABORT is a one-clock exit after a cancelled conversion.
- S_IDLE goes to S_QUAL when both lines are low and the start logic is armed.
- S_QUAL goes back to S_IDLE if either line rises, and on to S_CONV when the count reaches the qualifying width.
- S_CONV goes to S_LATCH after the last bit trial, or to S_ABORT on a qualified abort pulse.
- S_LATCH and S_ABORT both return to S_IDLE.

Top module: `sar_ctrl_core`

## Requirements
- R1: A conversion starts only after the sampled chip select and read/convert have both been low for PULSE_CLKS consecutive clocks. Either line may be the one that falls last. A shorter overlap starts nothing. After a start or an abort, no new start is taken until the two lines stop being low together.
- R2: conv_busy_n is 1 when idle. It goes to 0 one clock after qualification completes, and stays 0 until the output register has been loaded.
- R3: Bit trials run from bit 15 down to bit 0, with STEP_CLKS clocks per bit. trial_code shows the kept bits OR the bit under trial. A bit is kept when cmp_in is 1, meaning the input is at or above the trial level. conv_busy_n is low for DATA_W*STEP_CLKS+1 clocks in all.
- R4: The stored word is the trial result with its top bit inverted (two's complement). An input at positive full scale reads 7FFF, zero reads 0000, one step below zero reads FFFF, and negative full scale reads 8000.
- R5: Both lane enables are 1 only when, on the previous clock, read/convert was 1 and chip select was 0. Otherwise both enables are 0 and both lanes read 00.
- R6: With byte_sel 0, lane_hi carries result bits 15..8 and lane_lo carries bits 7..0. With byte_sel 1, the halves are swapped. byte_sel takes effect one clock after it is sampled.
- R7: During a conversion the previous result stays readable. The register changes only in the clock that follows the final bit trial.
- R8: During a conversion, a low pulse of at least PULSE_CLKS clocks on read/convert, after it was seen high, ends the conversion. conv_busy_n returns to 1 and the stored result and its flag stay unchanged.
- R9: result_bad is loaded with 1 when the conversion began fewer than ACQ_CLKS clocks after the previous conversion finished or was aborted. Otherwise it is loaded with 0.
- R10: After reset, conv_busy_n is 1, the result register is 0000, both lane enables are 0, result_bad is 0, and the acquisition interval counts as already satisfied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_conv | input | 1 | High: read, low: convert/abort |
| byte_sel | input | 1 | Swaps the byte halves between the lanes |
| cmp_in | input | 1 | Comparator: 1 when input is at or above trial level |
| trial_code | output | 16 | Code presented to the analog array |
| conv_busy_n | output | 1 | Low while a conversion is in progress |
| lane_hi | output | 8 | Upper output lane |
| lane_lo | output | 8 | Lower output lane |
| lane_hi_en | output | 1 | Upper lane driven |
| lane_lo_en | output | 1 | Lower lane driven |
| result_bad | output | 1 | Stored result was started without full acquisition |

## Verification
The bench goes after the qualification edge. An overlap one clock short must start nothing. A design that counts one clock too few would begin converting on glitches. It tries both trigger orders and holds both lines low through and past completion. A design without re-arming would restart on its own. It aborts mid-conversion and reads back the old word, which catches a design that latches partial trial bits. It also checks that a one-clock-short abort pulse is ignored. Finally, it starts a conversion immediately after the previous one finished and expects the bad flag. A design that never restarts its acquisition timer would report the result as clean.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_QUAL,
        S_CONV,
        S_LATCH,
        S_ABORT
    } sar_state_e;
endpackage

// File: rtl/sar_ctl_fsm.sv
module sar_ctl_fsm
    import sar_pkg::*;
#(
    parameter int PULSE_CLKS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       both_low,
    input  logic       rc_q,
    input  logic       bits_done,
    output sar_state_e state_o,
    output logic       start_o,
    output logic       latch_o,
    output logic       abort_o,
    output logic       run_o,
    output logic       busy_n_o
);
    localparam int CW = $clog2(PULSE_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(PULSE_CLKS - 1);

    sar_state_e state_q, state_d;
    logic [CW-1:0] qual_cnt;
    logic [CW-1:0] abort_cnt;
    logic          seen_high;
    logic          armed;
    logic          abort_hit;

    // An abort needs the line seen high since the start, then PULSE_CLKS lows.
    assign abort_hit = !rc_q && seen_high && (abort_cnt == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (both_low && armed) state_d = S_QUAL;
            S_QUAL: begin
                if (!both_low)              state_d = S_IDLE;
                else if (qual_cnt == LAST)  state_d = S_CONV;
            end
            S_CONV: begin
                if (abort_hit)              state_d = S_ABORT;
                else if (bits_done)         state_d = S_LATCH;
            end
            S_LATCH: state_d = S_IDLE;
            S_ABORT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // qualification / abort counters and start arming
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qual_cnt  <= '0;
            abort_cnt <= '0;
            seen_high <= 1'b0;
            armed     <= 1'b1;
        end else begin
            qual_cnt <= (state_d == S_QUAL) ? qual_cnt + 1'b1 : '0;
            if (start_o) begin
                abort_cnt <= '0;
                seen_high <= 1'b0;
            end else if (state_q == S_CONV) begin
                if (rc_q) seen_high <= 1'b1;
                abort_cnt <= (!rc_q && seen_high) ? abort_cnt + 1'b1 : '0;
            end
            if (start_o || abort_o) armed <= 1'b0;
            else if (!both_low)     armed <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        state_o  = state_q;
        start_o  = (state_q == S_QUAL) && both_low && (qual_cnt == LAST);
        latch_o  = (state_q == S_LATCH);
        abort_o  = (state_q == S_ABORT);
        run_o    = (state_q == S_CONV);
        busy_n_o = !((state_q == S_CONV) || (state_q == S_LATCH));
    end
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
    parameter int DATA_W    = 16,
    parameter int STEP_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    input  logic              cmp_in,
    output logic [DATA_W-1:0] trial_code,
    output logic [DATA_W-1:0] sar_code,
    output logic              last_step
);
    localparam int SW = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
    localparam int BW = $clog2(DATA_W);
    localparam logic [SW-1:0] STEP_LAST = SW'(STEP_CLKS - 1);

    logic [SW-1:0]     step_cnt;
    logic [BW-1:0]     bit_idx;
    logic [DATA_W-1:0] sar_q;
    logic [DATA_W-1:0] trial_bit;
    logic              step_end;

    assign step_end   = run && (step_cnt == STEP_LAST);
    assign last_step  = step_end && (bit_idx == '0);
    assign trial_bit  = {{(DATA_W-1){1'b0}}, 1'b1} << bit_idx;
    assign trial_code = run ? (sar_q | trial_bit) : sar_q;
    assign sar_code   = sar_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_cnt <= '0;
            bit_idx  <= BW'(DATA_W - 1);
        end else if (clear) begin
            step_cnt <= '0;
            bit_idx  <= BW'(DATA_W - 1);
        end else if (run) begin
            if (step_end) begin
                step_cnt <= '0;
                if (bit_idx != '0) bit_idx <= bit_idx - 1'b1;
            end else begin
                step_cnt <= step_cnt + 1'b1;
            end
        end
    end

    // one decision flop per bit position
    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               sar_q[g] <= 1'b0;
            else if (clear)                           sar_q[g] <= 1'b0;
            else if (step_end && bit_idx == BW'(g))   sar_q[g] <= cmp_in;
        end
    end
endmodule

// File: rtl/sar_acq_timer.sv
module sar_acq_timer #(
    parameter int ACQ_CLKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic ready
);
    localparam int AW = $clog2(ACQ_CLKS + 1);
    localparam logic [AW-1:0] FULL = AW'(ACQ_CLKS);

    logic [AW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= FULL;
        else if (restart)       cnt <= '0;
        else if (cnt != FULL)   cnt <= cnt + 1'b1;
    end

    assign ready = (cnt == FULL);
endmodule

// File: rtl/sar_out_port.sv
module sar_out_port #(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                latch,
    input  logic                acq_ready,
    input  logic [DATA_W-1:0]   sar_code,
    input  logic                drive_en,
    input  logic                swap,
    output logic [DATA_W/2-1:0] lane_hi,
    output logic [DATA_W/2-1:0] lane_lo,
    output logic                hi_en,
    output logic                lo_en,
    output logic [DATA_W-1:0]   result_word,
    output logic                result_bad
);
    localparam int LW = DATA_W / 2;

    logic [DATA_W-1:0] result_q;
    logic              pend_bad;
    logic              bad_q;
    logic [LW-1:0]     upper, lower;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            pend_bad <= 1'b0;
            bad_q    <= 1'b0;
        end else begin
            if (start) pend_bad <= !acq_ready;
            if (latch) begin
                result_q <= {~sar_code[DATA_W-1], sar_code[DATA_W-2:0]};
                bad_q    <= pend_bad;
            end
        end
    end

    assign upper       = result_q[DATA_W-1:LW];
    assign lower       = result_q[LW-1:0];
    assign hi_en       = drive_en;
    assign lo_en       = drive_en;
    assign lane_hi     = drive_en ? (swap ? lower : upper) : '0;
    assign lane_lo     = drive_en ? (swap ? upper : lower) : '0;
    assign result_word = result_q;
    assign result_bad  = bad_q;
endmodule

// File: rtl/sar_ctrl_core.sv
module sar_ctrl_core
    import sar_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int PULSE_CLKS = 10,
    parameter int STEP_CLKS  = 2,
    parameter int ACQ_CLKS   = DATA_W * STEP_CLKS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                rd_conv,
    input  logic                byte_sel,
    input  logic                cmp_in,
    output logic [DATA_W-1:0]   trial_code,
    output logic                conv_busy_n,
    output logic [DATA_W/2-1:0] lane_hi,
    output logic [DATA_W/2-1:0] lane_lo,
    output logic                lane_hi_en,
    output logic                lane_lo_en,
    output logic                result_bad
);
    logic              cs_q, rc_q, bs_q;
    logic              both_low;
    logic              start, latch, abort, run, bits_done, acq_ready;
    logic [DATA_W-1:0] sar_code;
    logic [DATA_W-1:0] result_word;
    sar_state_e        fsm_state;

    // control inputs sampled on the system clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= 1'b1;
            rc_q <= 1'b1;
            bs_q <= 1'b0;
        end else begin
            cs_q <= cs_n;
            rc_q <= rd_conv;
            bs_q <= byte_sel;
        end
    end

    assign both_low = !cs_q && !rc_q;

    sar_ctl_fsm #(.PULSE_CLKS(PULSE_CLKS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .both_low(both_low), .rc_q(rc_q),
        .bits_done(bits_done), .state_o(fsm_state), .start_o(start),
        .latch_o(latch), .abort_o(abort), .run_o(run), .busy_n_o(conv_busy_n)
    );

    sar_bit_engine #(.DATA_W(DATA_W), .STEP_CLKS(STEP_CLKS)) u_engine (
        .clk(clk), .rst_n(rst_n), .clear(start), .run(run), .cmp_in(cmp_in),
        .trial_code(trial_code), .sar_code(sar_code), .last_step(bits_done)
    );

    sar_acq_timer #(.ACQ_CLKS(ACQ_CLKS)) u_acq (
        .clk(clk), .rst_n(rst_n), .restart(latch || abort), .ready(acq_ready)
    );

    sar_out_port #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .start(start), .latch(latch),
        .acq_ready(acq_ready), .sar_code(sar_code),
        .drive_en(rc_q && !cs_q), .swap(bs_q),
        .lane_hi(lane_hi), .lane_lo(lane_lo),
        .hi_en(lane_hi_en), .lo_en(lane_lo_en),
        .result_word(result_word), .result_bad(result_bad)
    );
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk
    import sar_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int STEP_CLKS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              rd_conv,
    input logic              cs_q,
    input logic              rc_q,
    input logic              conv_busy_n,
    input logic              lane_hi_en,
    input logic              lane_lo_en,
    input logic [DATA_W-1:0] result_word,
    input sar_state_e        fsm_state
);
    localparam int CONV_CLKS = DATA_W * STEP_CLKS + 1;

    int low_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            low_cnt <= 0;
        else if (!conv_busy_n) low_cnt <= low_cnt + 1;
        else                   low_cnt <= 0;
    end

    p_start_both_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_busy_n) |-> $past(!cs_q && !rc_q));

    p_conv_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(conv_busy_n) && fsm_state != S_ABORT) |-> low_cnt == CONV_CLKS);

    p_lanes_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(rd_conv) && !$past(cs_n)) |-> (!lane_hi_en && !lane_lo_en));

    p_update_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_word) |-> $past(fsm_state) == S_LATCH);

    p_abort_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == S_ABORT |-> $stable(result_word));

    p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == S_ABORT |=> conv_busy_n);
endmodule

bind sar_ctrl_core sar_ctrl_chk #(.DATA_W(DATA_W), .STEP_CLKS(STEP_CLKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_conv(rd_conv),
    .cs_q(cs_q), .rc_q(rc_q), .conv_busy_n(conv_busy_n),
    .lane_hi_en(lane_hi_en), .lane_lo_en(lane_lo_en),
    .result_word(result_word), .fsm_state(fsm_state)
);

// File: tb/test_sar_ctrl_core.sv
module test_sar_ctrl_core;
    localparam int PULSE = 10;
    localparam int STEP  = 2;
    localparam int ACQ   = 16 * STEP;
    localparam int CONV  = 16 * STEP + 1;
    localparam int NVEC  = 6;
    localparam logic [15:0] VEC [NVEC] =
        '{16'h7FFF, 16'h0000, 16'hFFFF, 16'h8000, 16'h1234, 16'hA5A5};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_conv = 1'b1, byte_sel = 1'b0;
    logic        cmp_in;
    logic [15:0] trial_code;
    logic        conv_busy_n, lane_hi_en, lane_lo_en, result_bad;
    logic [7:0]  lane_hi, lane_lo;
    logic [15:0] target = 16'h0000;
    logic [15:0] prev   = 16'h0000;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    // comparator model: keep trial bit when input code >= trial code
    assign cmp_in = (trial_code <= (target ^ 16'h8000));

    sar_ctrl_core i_sar_ctrl_core (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_conv(rd_conv),
        .byte_sel(byte_sel), .cmp_in(cmp_in), .trial_code(trial_code),
        .conv_busy_n(conv_busy_n), .lane_hi(lane_hi), .lane_lo(lane_lo),
        .lane_hi_en(lane_hi_en), .lane_lo_en(lane_lo_en), .result_bad(result_bad)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // both lines low for PULSE clocks, then read line high; ends one clock after start
    task automatic start_conv();
        cs_n = 1'b0; rd_conv = 1'b0;
        tick(PULSE);
        rd_conv = 1'b1;
        chk("R2 busy high before start", conv_busy_n, 1);
        tick(1);
        chk("R2 busy low after start", conv_busy_n, 0);
    endtask

    task automatic wait_idle();
        int k = 0;
        while (!conv_busy_n && k < 200) begin tick(1); k++; end
    endtask

    task automatic read_word(output logic [15:0] w);
        cs_n = 1'b0; rd_conv = 1'b1; byte_sel = 1'b0;
        tick(2);
        w = {lane_hi, lane_lo};
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        tick(3);
        // R10 reset state
        chk("R10 busy after reset", conv_busy_n, 1);
        chk("R10 lanes disabled", {lane_hi_en, lane_lo_en}, 0);
        chk("R10 bad flag clear", result_bad, 0);
        rst_n = 1'b1;
        tick(2);
        read_word(w);
        chk("R10 result zero", w, 16'h0000);
        chk("R5 lanes enabled on read", {lane_hi_en, lane_lo_en}, 2'b11);

        // table walk: one conversion per vector
        for (int i = 0; i < NVEC; i++) begin
            target = VEC[i];
            start_conv();
            tick(2);
            chk("R3 trial after first bit", trial_code,
                ((target ^ 16'h8000) & 16'h8000) | 16'h4000);
            tick(3);
            chk("R7 previous result readable", {lane_hi, lane_lo}, prev);
            tick(27);
            chk("R3 busy still low at last clock", conv_busy_n, 0);
            tick(1);
            chk("R3 busy high at completion", conv_busy_n, 1);
            chk("R4 result word", {lane_hi, lane_lo}, target);
            chk("R9 clean after acquisition", result_bad, 0);
            byte_sel = 1'b1;
            tick(1);
            chk("R6 swapped lanes", {lane_hi, lane_lo}, {target[7:0], target[15:8]});
            byte_sel = 1'b0;
            tick(1);
            chk("R6 normal lanes", {lane_hi, lane_lo}, target);
            cs_n = 1'b1;
            tick(1);
            chk("R5 cs high disables", {lane_hi_en, lane_lo_en, lane_hi, lane_lo}, 18'h0);
            rd_conv = 1'b0;
            tick(1);
            chk("R5 cs high rc low disables", {lane_hi_en, lane_lo_en}, 0);
            rd_conv = 1'b1;
            prev = target;
            tick(ACQ + 4);
        end

        // R1 overlap one clock short
        target = 16'h3C3C;
        cs_n = 1'b0; rd_conv = 1'b0;
        tick(PULSE - 1);
        rd_conv = 1'b1;
        tick(6);
        chk("R1 short overlap no start", conv_busy_n, 1);
        read_word(w);
        chk("R1 result untouched", w, prev);

        // R1 chip select falls last
        cs_n = 1'b1; rd_conv = 1'b0;
        tick(20);
        chk("R1 cs high blocks start", conv_busy_n, 1);
        target = 16'h0F0F;
        cs_n = 1'b0;
        tick(PULSE + 1);
        chk("R1 cs-last start", conv_busy_n, 0);
        rd_conv = 1'b1;
        wait_idle();
        read_word(w);
        chk("R1 cs-last result", w, 16'h0F0F);
        prev = w;
        cs_n = 1'b1;
        tick(ACQ + 4);

        // R1 hold both low through completion: no restart
        target = 16'hC001;
        cs_n = 1'b0; rd_conv = 1'b0;
        tick(PULSE + 1);
        chk("R1 held-low start", conv_busy_n, 0);
        tick(CONV + 40);
        chk("R1 no restart while held low", conv_busy_n, 1);
        read_word(w);
        chk("R4 held-low result", w, 16'hC001);
        prev = w;
        cs_n = 1'b1;
        tick(ACQ + 4);

        // R8 abort mid-conversion
        target = 16'h5555;
        start_conv();
        tick(3);
        rd_conv = 1'b0;
        tick(PULSE + 2);
        chk("R8 busy released by abort", conv_busy_n, 1);
        rd_conv = 1'b1;
        tick(40);
        chk("R8 stays idle after abort", conv_busy_n, 1);
        read_word(w);
        chk("R8 result kept on abort", w, prev);
        chk("R8 flag kept on abort", result_bad, 0);
        cs_n = 1'b1;
        tick(ACQ + 4);

        // R8 abort pulse one clock short is ignored
        target = 16'h2468;
        start_conv();
        tick(3);
        rd_conv = 1'b0;
        tick(PULSE - 1);
        rd_conv = 1'b1;
        wait_idle();
        read_word(w);
        chk("R8 short abort ignored", w, 16'h2468);

        // R9 immediate restart without acquisition
        target = 16'h1111;
        start_conv();
        wait_idle();
        tick(1);
        chk("R9 early start flagged", result_bad, 1);
        chk("R4 early start data", {lane_hi, lane_lo}, 16'h1111);
        cs_n = 1'b1;
        tick(ACQ + 4);
        target = 16'h2222;
        start_conv();
        wait_idle();
        tick(1);
        chk("R9 flag cleared after acquisition", result_bad, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule